// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models a small parallel NOR flash device behind a simple synchronous bus. The bus has chip select, write and read strobes, a word address, and write and read data. The storage is an array of words split into equal sectors; with the default parameters that is four sectors of 64 sixteen-bit words. The low byte of every write is decoded by a multi-cycle command state machine. That machine decides what a later read returns: array contents, the status byte, or an entry of the device query table.

The supported operations are:
- **Sector erase:** two writes, a setup command and then a confirm.
- **Buffered program:** a setup command, a word count, a run of data words, and a closing confirm.
- **Lock and unlock:** accepted but protect nothing; they only set the ready flag.
- **Status read and status clear.**
- **Query-table read.**

No operation takes time. Each one completes on the clock edge that accepts its final write.

Top module: `nor_flash_cmd`

## Requirements
- R1: After reset the device is in read-array mode, every array word reads 0xFFFF, and the 8-bit status register is zero. Status reads return the status byte zero-extended to 16 bits. Command codes are taken from write-data bits 7:0 only.
- R2: In read-array mode, a write of 0x20 followed by a write of 0xD0 fills with ones the sector that holds the confirm write's address. That sector is address bits 7:6 with the default parameters. The erase sets status bit 7, and reads then return the status byte until the next command.
- R3: If the write after 0x20 is anything other than 0xD0, nothing is erased and the device returns to read-array mode.
- R4: A write of 0x50 clears the whole status register and returns to read-array mode. A write of 0x70 selects status reads and leaves the next write decoded as a fresh command.
- R5: A write of 0xE8 sets status bit 7. The following write carries the count N in its address-width low bits. The next N+1 writes are stored as data. A final write of 0xD0 sets ready and returns to read-array mode. The count write and data writes are never decoded as commands, even when their value is 0x00 or 0xFF.
- R6: During a buffered program, each data word is stored in the sector selected by the count write's address, at the offset given by the data write's own low address bits. A run that passes the sector's end therefore wraps inside that sector.
- R7: While a buffered program is in progress, reads return the status byte, with bit 7 set after each stored word.
- R8: A write of 0x60 followed by 0xD0 or 0x01 sets status bit 7 and returns to read-array mode. Any other second write returns to read-array mode and leaves the status unchanged. While the second write is pending, reads return the status byte.
- R9: After a write of 0x98, reads return query-table entry number (word address) in the low byte. The entries are:
  - 0x10–0x12: 0x51, 0x52, 0x59.
  - 0x13: 0x01.
  - 0x27: log2 of the size in bytes, which is 9 by default.
  - 0x2C: 0x01.
  - 0x2D–0x2E: sector count minus one.
  - Every address at or past 0x52 reads 0.

  Writes other than 0xFF or 0x00 leave query mode in place.
- R10: An unrecognised command byte written in read-array or status mode returns the device to read-array mode with no command pending.
- R11: A write of 0xFF or 0x00 returns the device to read-array mode from any command or confirm phase.
- R12: Read data is registered on the clock edge at which chip select and read enable are both high, and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, acts together with cs |
| re | input | 1 | Read strobe, acts together with cs |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data or command byte |
| rdata | output | DATA_W | Registered read data |

## Verification
The hardest behaviour to reach from the ports is the wrap of a buffered program inside the sector chosen by the count write. Reaching it takes a four-phase write sequence in which the data addresses deliberately point into a different sector from the count address. The bench runs that sequence with a data word of 0x00FF, so the same run also shows that data writes are never decoded as commands. It then reads back both the target sector and the sector the data addresses named. A closing sweep compares every word of the array against a reference array that the bench keeps.

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int SEC_W   = 6,
  parameter int QRY_LEN = 'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS      = 1 << ADDR_W;
  localparam int SECTORS    = 1 << (ADDR_W - SEC_W);
  localparam int SECT_BYTES = (1 << SEC_W) * (DATA_W / 8);
  localparam int SIZE_LOG2  = ADDR_W + $clog2(DATA_W / 8);

  localparam logic [7:0] C_READ = 8'h00, C_ERASE = 8'h20, C_CLR  = 8'h50,
                         C_LOCK = 8'h60, C_STAT  = 8'h70, C_QRY  = 8'h98,
                         C_PROG = 8'hE8, C_CONF  = 8'hD0, C_ARR  = 8'hFF,
                         C_ULCK = 8'h01;

  typedef enum logic [1:0] {PH_CMD, PH_ARG, PH_DATA, PH_CONF} phase_t;

  logic [DATA_W-1:0] mem [WORDS];
  phase_t            phase;
  logic [7:0]        cmd;
  logic [7:0]        status;
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-SEC_W-1:0] psec;
  logic [DATA_W-1:0] rd_val;

  wire       wr = cs & we;
  wire       rd = cs & re;
  wire [7:0] cb = wdata[7:0];
  wire       esc = (cb == C_ARR) || (cb == C_READ);

  function automatic logic [7:0] qry(input logic [ADDR_W-1:0] i);
    logic [7:0] v;
    v = 8'h00;
    if (32'(i) < QRY_LEN)
      case (32'(i))
        'h10: v = 8'h51;
        'h11: v = 8'h52;
        'h12: v = 8'h59;
        'h13: v = 8'h01;
        'h15: v = 8'h31;
        'h1B: v = 8'h45;
        'h1C: v = 8'h55;
        'h27: v = 8'(SIZE_LOG2);
        'h28: v = 8'h02;
        'h2C: v = 8'h01;
        'h2D: v = 8'(SECTORS - 1);
        'h2E: v = 8'((SECTORS - 1) >> 8);
        'h2F: v = 8'(SECT_BYTES >> 8);
        'h30: v = 8'(SECT_BYTES >> 16);
        default: v = 8'h00;
      endcase
    return v;
  endfunction

  always_comb begin
    if (cmd == C_READ)     rd_val = mem[addr];
    else if (cmd == C_QRY) rd_val = {{(DATA_W-8){1'b0}}, qry(addr)};
    else                   rd_val = {{(DATA_W-8){1'b0}}, status};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      phase  <= PH_CMD;
      cmd    <= C_READ;
      status <= '0;
      cnt    <= '0;
      psec   <= '0;
      rdata  <= '0;
    end else begin
      if (rd) rdata <= rd_val;
      if (wr) begin
        case (phase)
          PH_CMD: begin
            case (cb)
              C_READ, C_ARR: cmd <= C_READ;
              C_CLR:  begin status <= '0; cmd <= C_READ; end
              C_STAT: cmd <= C_STAT;
              C_ERASE, C_LOCK, C_QRY: begin cmd <= cb; phase <= PH_ARG; end
              C_PROG: begin cmd <= C_PROG; phase <= PH_ARG; status[7] <= 1'b1; end
              default: cmd <= C_READ;
            endcase
          end
          PH_ARG: begin
            if (cmd == C_PROG) begin
              cnt   <= wdata[ADDR_W-1:0];
              psec  <= addr[ADDR_W-1:SEC_W];
              phase <= PH_DATA;
            end else if (esc) begin
              cmd   <= C_READ;
              phase <= PH_CMD;
            end else begin
              case (cmd)
                C_ERASE: begin
                  phase <= PH_CMD;
                  if (cb == C_CONF) begin
                    for (int i = 0; i < WORDS; i++)
                      if ((i >> SEC_W) == int'(addr >> SEC_W)) mem[i] <= '1;
                    status[7] <= 1'b1;
                  end else cmd <= C_READ;
                end
                C_LOCK: begin
                  if (cb == C_CONF || cb == C_ULCK) status[7] <= 1'b1;
                  cmd   <= C_READ;
                  phase <= PH_CMD;
                end
                C_QRY: ;
                default: begin cmd <= C_READ; phase <= PH_CMD; end
              endcase
            end
          end
          PH_DATA: begin
            mem[{psec, addr[SEC_W-1:0]}] <= wdata;
            status[7] <= 1'b1;
            if (cnt == '0) phase <= PH_CONF;
            else           cnt <= cnt - 1'b1;
          end
          PH_CONF: begin
            if (cb == C_CONF) status[7] <= 1'b1;
            cmd   <= C_READ;
            phase <= PH_CMD;
          end
          default: begin cmd <= C_READ; phase <= PH_CMD; end
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic              re,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        phase,
  input logic [7:0]        cmd,
  input logic [7:0]        status,
  input logic [ADDR_W-1:0] cnt
);
  wire       wr = cs & we;
  wire [7:0] cb = wdata[7:0];
  wire known = cb == 8'h00 || cb == 8'hFF || cb == 8'h20 || cb == 8'h50 ||
               cb == 8'h60 || cb == 8'h70 || cb == 8'h98 || cb == 8'hE8;

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd0 && cb == 8'h50 |=> status == 8'h00 && cmd == 8'h00); // R4
  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd1 && cmd == 8'h20 && cb == 8'hD0 |=> status[7] && phase == 2'd0); // R2
  AST_PROG_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd2 && cnt == '0 |=> phase == 2'd3); // R5
  AST_PROG_WORD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd2 |=> status[7]); // R7
  AST_BAD_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd0 && !known |=> cmd == 8'h00 && phase == 2'd0); // R10
  AST_LOCK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && phase == 2'd1 && cmd == 8'h60 |=> phase == 2'd0 && cmd == 8'h00); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && re) |=> $stable(rdata)); // R12
endmodule

bind nor_flash_cmd nor_flash_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .wdata(wdata),
  .rdata(rdata), .phase(phase), .cmd(cmd), .status(status), .cnt(cnt));

// File: tb/tb_nor_flash_cmd.sv
`timescale 1ns/1ps
module tb_nor_flash_cmd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] refm [256];
  int          nvec = 0, nfail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  nor_flash_cmd dut (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk); cs = 1; re = 1; addr = a;
    @(negedge clk); cs = 0; re = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 erased word 0x00", 8'h00, 16'hFFFF);
    rd_chk("R1 erased word 0xFF", 8'hFF, 16'hFFFF);
    wr(8'h00, 16'h0070);
    rd_chk("R1 status zero after reset", 8'h00, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_program;
    wr(8'h05, 16'h00E8);
    rd_chk("R7 ready after setup", 8'h05, 16'h0080);
    wr(8'h05, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      wr(8'(5 + i), 16'hA000 + 16'(i));
      refm[5 + i] = 16'hA000 + 16'(i);
      rd_chk("R7 status during data", 8'h05, 16'h0080);
    end
    wr(8'h00, 16'h00D0);
    for (int i = 0; i < 4; i++)
      rd_chk("R5 programmed word", 8'(5 + i), 16'hA000 + 16'(i));
  endtask

  task automatic t_wrap;
    wr(8'h80, 16'h00E8);
    wr(8'h83, 16'h0001);
    wr(8'h02, 16'h1234);
    wr(8'h03, 16'h00FF);
    refm[8'h82] = 16'h1234;
    refm[8'h83] = 16'h00FF;
    wr(8'h00, 16'h00D0);
    rd_chk("R6 wrap into sector 2", 8'h82, 16'h1234);
    rd_chk("R5 0x00FF stored as data", 8'h83, 16'h00FF);
    rd_chk("R6 sector 0 untouched", 8'h02, 16'hFFFF);
  endtask

  task automatic t_erase;
    wr(8'h45, 16'h00E8); wr(8'h45, 16'h0000); wr(8'h45, 16'h5555); wr(8'h45, 16'h00D0);
    rd_chk("R5 single word", 8'h45, 16'h5555);
    wr(8'h00, 16'h0050);
    rd_chk("R4 array after clear", 8'h05, 16'hA000);
    wr(8'h00, 16'h0070);
    rd_chk("R4 status cleared", 8'h00, 16'h0000);
    wr(8'h47, 16'h0020);
    wr(8'h40, 16'h00D0);
    for (int i = 8'h40; i < 8'h80; i++) refm[i] = 16'hFFFF;
    rd_chk("R2 status after erase", 8'h40, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R2 sector erased", 8'h45, 16'hFFFF);
    rd_chk("R2 other sector kept", 8'h05, 16'hA000);
  endtask

  task automatic t_erase_abort;
    wr(8'hC1, 16'h00E8); wr(8'hC1, 16'h0000); wr(8'hC1, 16'hBEEF); wr(8'hC1, 16'h00D0);
    refm[8'hC1] = 16'hBEEF;
    wr(8'hC0, 16'h0020); wr(8'hC0, 16'h0033);
    rd_chk("R3 bad confirm no erase", 8'hC1, 16'hBEEF);
    wr(8'hC0, 16'h0020); wr(8'hC0, 16'h0000);
    rd_chk("R11 0x00 escapes erase", 8'hC1, 16'hBEEF);
  endtask

  task automatic t_lock;
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0060);
    rd_chk("R8 status while pending", 8'h00, 16'h0000);
    wr(8'h00, 16'h0001);
    rd_chk("R8 array after unlock", 8'h05, 16'hA000);
    wr(8'h00, 16'h0070);
    rd_chk("R8 ready after unlock", 8'h00, 16'h0080);
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0077);
    rd_chk("R8 array after bad lock", 8'h05, 16'hA000);
    wr(8'h00, 16'h0070);
    rd_chk("R8 status unchanged", 8'h00, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_query;
    wr(8'h00, 16'h0098);
    rd_chk("R9 Q", 8'h10, 16'h0051);
    rd_chk("R9 R", 8'h11, 16'h0052);
    rd_chk("R9 Y", 8'h12, 16'h0059);
    rd_chk("R9 command set", 8'h13, 16'h0001);
    rd_chk("R9 size log2", 8'h27, 16'h0009);
    rd_chk("R9 regions", 8'h2C, 16'h0001);
    rd_chk("R9 sectors-1 low", 8'h2D, 16'h0003);
    rd_chk("R9 sectors-1 high", 8'h2E, 16'h0000);
    rd_chk("R9 end of table", 8'h52, 16'h0000);
    rd_chk("R9 past table", 8'h90, 16'h0000);
    wr(8'h00, 16'h0042);
    rd_chk("R9 stays in query", 8'h10, 16'h0051);
    wr(8'h00, 16'h00FF);
    rd_chk("R9 leave query", 8'h05, 16'hA000);
    wr(8'h00, 16'h0098); wr(8'h00, 16'h0000);
    rd_chk("R11 0x00 leaves query", 8'h10, 16'hFFFF);
  endtask

  task automatic t_unknown;
    wr(8'h00, 16'h0041);
    rd_chk("R10 unknown in array mode", 8'h05, 16'hA000);
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h00C3);
    rd_chk("R10 unknown in status mode", 8'h05, 16'hA000);
  endtask

  task automatic t_latency;
    rd_chk("R12 read", 8'h05, 16'hA000);
    repeat (3) @(negedge clk);
    chk("R12 hold without read", rdata, 16'hA000);
    cs = 1; re = 1; addr = 8'hC1;
    #1 chk("R12 no change before edge", rdata, 16'hA000);
    @(negedge clk); cs = 0; re = 0;
    chk("R12 registered after edge", rdata, 16'hBEEF);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 256; i++) rd_chk("R1 R5 array sweep", 8'(i), refm[i]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refm[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_wrap();
    t_erase();
    t_erase_abort();
    t_lock();
    t_query();
    t_unknown();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule